// File: doc/BRIEF.md
# Memory Map Router with I/O Register Bank

This block sits between a small three-stage integer core and its on-chip memories. Each cycle it looks at the fetch PC and the data address and raises the enables of the memory that owns each access: instruction memory or boot memory for fetches; instruction memory (write-only), boot memory (read-only), data memory or the I/O bank for loads and stores. Decoding uses only the top four address bits. A store into instruction memory is allowed only while the core is executing out of boot memory, which lets the boot loader copy a program in before jumping to it.

All memories respond one cycle after the address is presented. The block therefore registers the source of each load and selects the returned word on the following cycle. Loads from the I/O bank are registered at the same point, so they line up with memory data. The I/O bank holds a serial-port status word, the received byte, the transmit byte, a free-running clock-cycle counter and a retired-instruction counter. Software can clear both counters with one store.

Top module: `memmap_router`

## Requirements
- R1: A fetch PC whose bits 31:28 are 0001 raises `fetch_imem_en`, and one whose bits are 0100 raises `fetch_boot_en`. Any other value raises neither. `fetch_from_boot` is the value of `fetch_boot_en` registered one cycle earlier.
- R2: A store with data address bits 31:28 equal to 001x raises `imem_wen` only while `fetch_pc[30]` is 1. No load ever enables instruction memory through the data port.
- R3: A data address with bits 31:28 equal to 00x1 reaches data memory. `dmem_en` rises on a load or a store, and `dmem_wen` rises on a store only. Address 0011 can therefore write both instruction and data memory.
- R4: Bits 31:28 equal to 0100 raise `boot_den` on a load only. A store there enables no memory.
- R5: `mem_wmask` equals `d_wmask` whenever `imem_wen` or `dmem_wen` is high, and is zero otherwise.
- R6: Load data appears on `d_rdata` in the cycle after the load. It comes from boot memory, data memory or the I/O bank according to the decoded region.
- R7: A load from 0x80000000 returns zero in bits 31:2, the receive-valid input in bit 1 and the transmit-ready input in bit 0, as they stood in the load cycle.
- R8: A load from 0x80000004 returns the received byte zero-extended. If `uart_rx_valid` was high in that cycle, `uart_rx_ready` pulses high for exactly the next cycle.
- R9: A store to 0x80000008 while `uart_tx_ready` is high drives `uart_tx_valid` high for the next cycle only, with `uart_tx_byte` equal to write-data bits 7:0. While `uart_tx_ready` is low, the store is dropped.
- R10: The cycle counter at 0x80000010 rises by one every clock cycle. A store of any value to 0x80000018 sets it to zero at the end of that cycle.
- R11: The instruction counter at 0x80000014 rises by one for each cycle in which `retire` is high. The same clearing store zeroes it, and clearing wins over a retire in the same cycle.
- R12: A load from an address outside all regions, from instruction memory, or from an unassigned I/O offset (for example 0x8000000C) returns zero. A store to such an address changes no output and no counter.
- R13: While `rst` is high and right after it, `uart_rx_ready`, `uart_tx_valid`, `fetch_from_boot` and `d_rdata` are zero, and both counters start from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | PC of the instruction being fetched |
| d_addr | input | 32 | Load/store byte address |
| d_re | input | 1 | Load request |
| d_we | input | 1 | Store request |
| d_wdata | input | 32 | Store data |
| d_wmask | input | 4 | Byte write mask of the store |
| retire | input | 1 | A valid, non-flushed instruction retires this cycle |
| uart_rx_valid | input | 1 | Receiver holds a byte |
| uart_rx_byte | input | 8 | Received byte |
| uart_tx_ready | input | 1 | Transmitter can accept a byte |
| boot_rdata | input | 32 | Boot memory data-port read word |
| dmem_rdata | input | 32 | Data memory read word |
| fetch_imem_en | output | 1 | Instruction memory fetch enable |
| fetch_boot_en | output | 1 | Boot memory fetch enable |
| fetch_from_boot | output | 1 | Current instruction word comes from boot memory |
| imem_wen | output | 1 | Instruction memory write enable |
| dmem_en | output | 1 | Data memory access enable |
| dmem_wen | output | 1 | Data memory write enable |
| boot_den | output | 1 | Boot memory data-port read enable |
| mem_wmask | output | 4 | Shared byte write mask |
| d_rdata | output | 32 | Load data, one cycle after the load |
| uart_rx_ready | output | 1 | Byte consumed from the receiver |
| uart_tx_valid | output | 1 | Byte offered to the transmitter |
| uart_tx_byte | output | 8 | Byte to transmit |

## Verification
The bench targets the aliased region 0011, which must write both memories: a decoder that split 001x and 00x1 exclusively would miss one of the two enables. It also stores into instruction memory from a PC with bit 30 clear, which a decoder that ignored the boot-mode gate would let through. It reads back both counters a known number of cycles after a clear that coincides with a retire pulse. An off-by-one in when the counter is sampled, or a retire that wins over the clear, shows up as a count one too high. Handshake tests issue receive loads with no byte pending and transmit stores while the transmitter is busy, where a block that ignored the flags would emit stray pulses. Reads of the unassigned I/O slot and of the write-only region catch a read mux that falls through to stale data.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_BOOT = 2'd1,
    SRC_DMEM = 2'd2,
    SRC_IO   = 2'd3
  } rsrc_e;

  localparam logic [3:0] NIB_FETCH_IMEM = 4'b0001;
  localparam logic [3:0] NIB_BOOT       = 4'b0100;
  localparam logic [3:0] NIB_IO         = 4'b1000;

  // word index (address bits 4:2) inside the I/O region
  localparam logic [2:0] IOW_STATUS = 3'd0;
  localparam logic [2:0] IOW_RXBYTE = 3'd1;
  localparam logic [2:0] IOW_TXBYTE = 3'd2;
  localparam logic [2:0] IOW_CYCLES = 3'd4;
  localparam logic [2:0] IOW_RETIRE = 3'd5;
  localparam logic [2:0] IOW_CLEAR  = 3'd6;
endpackage

// File: rtl/memmap_addr_dec.sv
module memmap_addr_dec
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic              d_re,
  input  logic              d_we,
  output logic              fetch_imem_en,
  output logic              fetch_boot_en,
  output logic              imem_wen,
  output logic              dmem_en,
  output logic              dmem_wen,
  output logic              boot_den,
  output logic              io_hit,
  output rsrc_e             rd_src
);
  localparam int NIB_LSB  = ADDR_W - 4;
  localparam int BOOT_BIT = ADDR_W - 2;

  logic [3:0] f_nib, d_nib;
  logic       in_imem_w, in_dmem, in_boot, in_io;

  assign f_nib = fetch_pc[ADDR_W-1:NIB_LSB];
  assign d_nib = d_addr[ADDR_W-1:NIB_LSB];

  assign fetch_imem_en = (f_nib == NIB_FETCH_IMEM);
  assign fetch_boot_en = (f_nib == NIB_BOOT);

  assign in_imem_w = (d_nib[3:1] == 3'b001);
  assign in_dmem   = (d_nib[3:2] == 2'b00) && d_nib[0];
  assign in_boot   = (d_nib == NIB_BOOT);
  assign in_io     = (d_nib == NIB_IO);

  assign imem_wen = in_imem_w && d_we && fetch_pc[BOOT_BIT];
  assign dmem_en  = in_dmem && (d_re || d_we);
  assign dmem_wen = in_dmem && d_we;
  assign boot_den = in_boot && d_re;
  assign io_hit   = in_io;

  always_comb begin
    rd_src = SRC_NONE;
    if (d_re) begin
      if (in_dmem)      rd_src = SRC_DMEM;
      else if (in_boot) rd_src = SRC_BOOT;
      else if (in_io)   rd_src = SRC_IO;
    end
  end
endmodule

// File: rtl/memmap_io_bank.sv
module memmap_io_bank
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_hit,
  input  logic              d_re,
  input  logic              d_we,
  input  logic [ADDR_W-5:0] offset,
  input  logic [DATA_W-1:0] wdata,
  input  logic              retire,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] io_rdata,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte
);
  localparam int NCNT = 2;

  logic       slot_ok, rd, wr;
  logic [2:0] word;
  logic       clear;
  logic [CNT_W-1:0] cnt [NCNT];
  logic [DATA_W-1:0] rd_val;

  assign word    = offset[4:2];
  assign slot_ok = io_hit && (offset[ADDR_W-5:5] == '0);
  assign rd      = slot_ok && d_re;
  assign wr      = slot_ok && d_we;
  assign clear   = wr && (word == IOW_CLEAR);

  // counter 0 counts clock cycles, counter 1 counts retired instructions
  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic bump;
    if (i == 0) begin : g_cyc
      assign bump = 1'b1;
    end else begin : g_ret
      assign bump = retire;
    end
    always_ff @(posedge clk) begin
      if (rst || clear) cnt[i] <= '0;
      else if (bump)    cnt[i] <= cnt[i] + 1'b1;
    end
  end

  always_comb begin
    rd_val = '0;
    case (word)
      IOW_STATUS: rd_val[1:0] = {rx_valid, tx_ready};
      IOW_RXBYTE: rd_val[7:0] = rx_byte;
      IOW_CYCLES: rd_val = DATA_W'(cnt[0]);
      IOW_RETIRE: rd_val = DATA_W'(cnt[1]);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
      rx_ready <= 1'b0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      io_rdata <= rd ? rd_val : '0;
      rx_ready <= rd && (word == IOW_RXBYTE) && rx_valid;
      tx_valid <= wr && (word == IOW_TXBYTE) && tx_ready;
      if (wr && (word == IOW_TXBYTE) && tx_ready) tx_byte <= wdata[7:0];
    end
  end
endmodule

// File: rtl/memmap_rd_mux.sv
module memmap_rd_mux
  import memmap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  rsrc_e             rd_src,
  input  logic [DATA_W-1:0] boot_rdata,
  input  logic [DATA_W-1:0] dmem_rdata,
  input  logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] d_rdata
);
  rsrc_e src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= SRC_NONE;
    else     src_q <= rd_src;
  end

  always_comb begin
    case (src_q)
      SRC_BOOT: d_rdata = boot_rdata;
      SRC_DMEM: d_rdata = dmem_rdata;
      SRC_IO:   d_rdata = io_rdata;
      default:  d_rdata = '0;
    endcase
  end
endmodule

// File: rtl/memmap_router.sv
module memmap_router
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic              d_re,
  input  logic              d_we,
  input  logic [DATA_W-1:0] d_wdata,
  input  logic [STRB_W-1:0] d_wmask,
  input  logic              retire,
  input  logic              uart_rx_valid,
  input  logic [7:0]        uart_rx_byte,
  input  logic              uart_tx_ready,
  input  logic [DATA_W-1:0] boot_rdata,
  input  logic [DATA_W-1:0] dmem_rdata,
  output logic              fetch_imem_en,
  output logic              fetch_boot_en,
  output logic              fetch_from_boot,
  output logic              imem_wen,
  output logic              dmem_en,
  output logic              dmem_wen,
  output logic              boot_den,
  output logic [STRB_W-1:0] mem_wmask,
  output logic [DATA_W-1:0] d_rdata,
  output logic              uart_rx_ready,
  output logic              uart_tx_valid,
  output logic [7:0]        uart_tx_byte
);
  logic              io_hit;
  rsrc_e             rd_src;
  logic [DATA_W-1:0] io_rdata;

  memmap_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .fetch_pc      (fetch_pc),
    .d_addr        (d_addr),
    .d_re          (d_re),
    .d_we          (d_we),
    .fetch_imem_en (fetch_imem_en),
    .fetch_boot_en (fetch_boot_en),
    .imem_wen      (imem_wen),
    .dmem_en       (dmem_en),
    .dmem_wen      (dmem_wen),
    .boot_den      (boot_den),
    .io_hit        (io_hit),
    .rd_src        (rd_src)
  );

  memmap_io_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_io (
    .clk      (clk),
    .rst      (rst),
    .io_hit   (io_hit),
    .d_re     (d_re),
    .d_we     (d_we),
    .offset   (d_addr[ADDR_W-5:0]),
    .wdata    (d_wdata),
    .retire   (retire),
    .rx_valid (uart_rx_valid),
    .rx_byte  (uart_rx_byte),
    .tx_ready (uart_tx_ready),
    .io_rdata (io_rdata),
    .rx_ready (uart_rx_ready),
    .tx_valid (uart_tx_valid),
    .tx_byte  (uart_tx_byte)
  );

  memmap_rd_mux #(.DATA_W(DATA_W)) u_mux (
    .clk        (clk),
    .rst        (rst),
    .rd_src     (rd_src),
    .boot_rdata (boot_rdata),
    .dmem_rdata (dmem_rdata),
    .io_rdata   (io_rdata),
    .d_rdata    (d_rdata)
  );

  // one shared byte mask, qualified by the per-target write enables
  assign mem_wmask = (imem_wen || dmem_wen) ? d_wmask : '0;

  always_ff @(posedge clk) begin
    if (rst) fetch_from_boot <= 1'b0;
    else     fetch_from_boot <= fetch_boot_en;
  end
endmodule

// File: rtl/memmap_router_chk.sv
module memmap_router_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] fetch_pc,
  input logic        d_re,
  input logic        d_we,
  input logic [3:0]  d_wmask,
  input logic        uart_tx_ready,
  input logic        uart_rx_valid,
  input logic        fetch_imem_en,
  input logic        fetch_boot_en,
  input logic        imem_wen,
  input logic        dmem_wen,
  input logic        boot_den,
  input logic [3:0]  mem_wmask,
  input logic        uart_rx_ready,
  input logic        uart_tx_valid
);
  // R1
  fetch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fetch_imem_en && fetch_boot_en));
  // R2
  imem_boot_only_chk: assert property (@(posedge clk) disable iff (rst)
    imem_wen |-> (fetch_pc[30] && d_we));
  // R3
  dmem_store_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_wen |-> d_we);
  // R4
  boot_load_only_chk: assert property (@(posedge clk) disable iff (rst)
    boot_den |-> (d_re && !dmem_wen));
  // R5
  shared_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (imem_wen || dmem_wen) |-> (mem_wmask == d_wmask));
  // R8
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    uart_rx_ready |-> ($past(d_re) && $past(uart_rx_valid)));
  // R9
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    uart_tx_valid |-> ($past(d_we) && $past(uart_tx_ready)));
endmodule

bind memmap_router memmap_router_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .fetch_pc      (fetch_pc),
  .d_re          (d_re),
  .d_we          (d_we),
  .d_wmask       (d_wmask),
  .uart_tx_ready (uart_tx_ready),
  .uart_rx_valid (uart_rx_valid),
  .fetch_imem_en (fetch_imem_en),
  .fetch_boot_en (fetch_boot_en),
  .imem_wen      (imem_wen),
  .dmem_wen      (dmem_wen),
  .boot_den      (boot_den),
  .mem_wmask     (mem_wmask),
  .uart_rx_ready (uart_rx_ready),
  .uart_tx_valid (uart_tx_valid)
);

// File: tb/tb_memmap_router.sv
module tb_memmap_router;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] fetch_pc, d_addr, d_wdata, boot_rdata, dmem_rdata;
  logic        d_re, d_we, retire, uart_rx_valid, uart_tx_ready;
  logic [3:0]  d_wmask;
  logic [7:0]  uart_rx_byte;
  logic        fetch_imem_en, fetch_boot_en, fetch_from_boot, imem_wen;
  logic        dmem_en, dmem_wen, boot_den, uart_rx_ready, uart_tx_valid;
  logic [3:0]  mem_wmask;
  logic [31:0] d_rdata;
  logic [7:0]  uart_tx_byte;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  memmap_router dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    d_re = 1'b0; d_we = 1'b0; retire = 1'b0;
    d_addr = 32'hF000_0000; d_wdata = '0; d_wmask = '0;
  endtask

  // presents a load at a negedge, returns the word one edge later
  task automatic load(input logic [31:0] a, output logic [31:0] v);
    d_addr = a; d_re = 1'b1;
    @(negedge clk);
    d_re = 1'b0; d_addr = 32'hF000_0000;
    v = d_rdata;
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] w);
    d_addr = a; d_wdata = w; d_we = 1'b1; d_wmask = 4'hF;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R13 rx_ready", {31'b0, uart_rx_ready}, 0);
    chk("R13 tx_valid", {31'b0, uart_tx_valid}, 0);
    chk("R13 from_boot", {31'b0, fetch_from_boot}, 0);
    chk("R13 rdata", d_rdata, 0);
  endtask

  task automatic t_fetch();
    fetch_pc = 32'h1000_0040; #1;
    chk("R1 imem fetch", {30'b0, fetch_imem_en, fetch_boot_en}, 32'h2);
    fetch_pc = 32'h4000_0000; #1;
    chk("R1 boot fetch", {30'b0, fetch_imem_en, fetch_boot_en}, 32'h1);
    @(negedge clk);
    chk("R1 from_boot", {31'b0, fetch_from_boot}, 1);
    fetch_pc = 32'h7000_0000; #1;
    chk("R1 none", {30'b0, fetch_imem_en, fetch_boot_en}, 0);
    @(negedge clk);
    chk("R1 from_boot low", {31'b0, fetch_from_boot}, 0);
  endtask

  task automatic t_writes();
    fetch_pc = 32'h4000_0100;
    d_addr = 32'h2000_0008; d_we = 1'b1; d_wmask = 4'b0110; #1;
    chk("R2 imem from boot", {29'b0, imem_wen, dmem_wen, boot_den}, 32'h4);
    chk("R5 mask", {28'b0, mem_wmask}, 32'h6);
    d_addr = 32'h3000_0000; #1;
    chk("R3 alias both", {29'b0, imem_wen, dmem_wen, dmem_en}, 32'h7);
    fetch_pc = 32'h1000_0000; #1;
    chk("R2 gated by pc30", {30'b0, imem_wen, dmem_wen}, 32'h1);
    d_addr = 32'h4000_0000; #1;
    chk("R4 boot store dropped", {28'b0, imem_wen, dmem_wen, dmem_en, boot_den}, 0);
    chk("R5 mask zero", {28'b0, mem_wmask}, 0);
    d_we = 1'b0; d_re = 1'b1; #1;
    chk("R4 boot load", {31'b0, boot_den}, 1);
    d_addr = 32'h2000_0000; #1;
    chk("R2 no imem load", {29'b0, imem_wen, dmem_en, boot_den}, 0);
    d_addr = 32'h1000_0000; #1;
    chk("R3 dmem load", {30'b0, dmem_en, dmem_wen}, 32'h2);
    idle();
    @(negedge clk);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    load(32'h4000_0010, v); chk("R6 boot data", v, boot_rdata);
    load(32'h1000_0004, v); chk("R6 dmem data", v, dmem_rdata);
    load(32'h3000_0004, v); chk("R6 dmem alias", v, dmem_rdata);
    load(32'h2000_0000, v); chk("R12 imem read zero", v, 0);
    load(32'hF000_0000, v); chk("R12 undecoded zero", v, 0);
    load(32'h8000_000C, v); chk("R12 io hole zero", v, 0);
  endtask

  task automatic t_uart();
    logic [31:0] v;
    uart_rx_valid = 1'b1; uart_tx_ready = 1'b0; uart_rx_byte = 8'hA5;
    load(32'h8000_0000, v); chk("R7 status rx", v, 32'h2);
    uart_rx_valid = 1'b0; uart_tx_ready = 1'b1;
    load(32'h8000_0000, v); chk("R7 status tx", v, 32'h1);
    chk("R8 no rx pulse on status", {31'b0, uart_rx_ready}, 0);
    uart_rx_valid = 1'b1;
    load(32'h8000_0004, v); chk("R8 rx byte", v, 32'hA5);
    chk("R8 rx pulse", {31'b0, uart_rx_ready}, 1);
    @(negedge clk);
    chk("R8 rx pulse ends", {31'b0, uart_rx_ready}, 0);
    uart_rx_valid = 1'b0;
    load(32'h8000_0004, v);
    chk("R8 no pulse when empty", {31'b0, uart_rx_ready}, 0);
    store(32'h8000_0008, 32'h1234_5677);
    chk("R9 tx pulse", {23'b0, uart_tx_valid, uart_tx_byte}, 32'h177);
    @(negedge clk);
    chk("R9 tx pulse ends", {31'b0, uart_tx_valid}, 0);
    uart_tx_ready = 1'b0;
    store(32'h8000_0008, 32'h0000_0011);
    chk("R9 busy dropped", {31'b0, uart_tx_valid}, 0);
    uart_tx_ready = 1'b1;
    store(32'h8000_000C, 32'h0000_0022);
    chk("R12 hole store no tx", {31'b0, uart_tx_valid}, 0);
  endtask

  task automatic t_counters();
    logic [31:0] v;
    d_addr = 32'h8000_0018; d_we = 1'b1; d_wdata = 32'hDEAD_BEEF; retire = 1'b1;
    @(negedge clk);
    idle(); retire = 1'b1;
    repeat (3) @(negedge clk);
    retire = 1'b0;
    @(negedge clk);
    load(32'h8000_0010, v); chk("R10 cycle count", v, 4);
    load(32'h8000_0014, v); chk("R11 retire count", v, 3);
    store(32'hF000_0018, 32'h0);
    store(32'h8000_000C, 32'h0);
    load(32'h8000_0010, v); chk("R12 stores did not clear", v, 8);
  endtask

  initial begin
    rst = 1'b1; fetch_pc = '0; idle();
    uart_rx_valid = 1'b0; uart_rx_byte = '0; uart_tx_ready = 1'b0;
    boot_rdata = 32'hB007_0001; dmem_rdata = 32'hD0D0_0002;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fetch();
    t_writes();
    t_readback();
    t_uart();
    t_counters();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule